// File: doc/BRIEF.md
# Reset-Source Status Flag Register

This block is an 8-bit status and flag register inside a clock, reset and power management unit. It records the cause of the most recent device reset (power-on, low-voltage, illegal address), latches a timeout flag from a periodic timer, latches changes of the PLL lock and oscillator status levels, and mirrors those two levels live. Software reads it over a simple register bus and clears latched flags by writing 1 to them. The timeout flag, gated by an enable input, drives an interrupt request.

Two reset domains act on the register. The asynchronous active-low power-on reset puts every flag in its power-on state. The synchronous active-high system reset clears only the timer, lock-change and oscillator-change flags, and it leaves the three reset-cause flags as they were. A small domain state machine has three states. POWER_UP is entered while power-on reset is applied. ACTIVE is the normal operating state. SYS_HOLD is the state during a system reset. Its transitions are: POWER_UP to SYS_HOLD when the system reset is asserted at the first clock after power-on release; POWER_UP to ACTIVE when it is not; ACTIVE to SYS_HOLD when the system reset is asserted; SYS_HOLD to ACTIVE when the system reset is released. Bus writes and timer, lock and oscillator events take effect only in ACTIVE while the system reset is low. Low-voltage and illegal-address cause events take effect in every state once power-on reset is released.

Top module: `rsf_status_reg`

## Requirements
- R1: During and after power-on reset, bit 6 (power-on cause) and bit 5 (low-voltage cause) read 1, and bits 7, 4, 2 and 1 read 0. Bit 3 reads the lock level and bit 0 reads the oscillator level.
- R2: A `tick_evt` pulse sets bit 7, which becomes visible after the next clock edge. Writing 1 to bit 7 clears it. Writing 0 leaves it unchanged.
- R3: `tick_irq` is high exactly while bit 7 is set and `tick_ie` is high.
- R4: A system reset clears bits 7, 4 and 1 and leaves bits 6, 5 and 2 unchanged.
- R5: `lvr_evt` sets bit 5 and `ila_evt` sets bit 2, also while the system reset is held. Bits 6, 5 and 2 each clear when 1 is written to them.
- R6: In ACTIVE, a change of `pll_locked` sets bit 4 and a change of `osc_up` sets bit 1. Both bits are write-1-to-clear. A level change that happens during a system reset sets neither bit.
- R7: Bit 3 mirrors `pll_locked` and bit 0 mirrors `osc_up`. Writes to bits 3 and 0 have no effect.
- R8: If a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: A write to an address other than `REG_ADDR` changes nothing. A read at another address returns 0.
- R10: Bus writes issued while the system reset is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Write data; a 1 clears the matching flag |
| bus_rdata | output | 8 | Read data; the register when the address matches, else 0 |
| tick_evt | input | 1 | End-of-period pulse from the periodic timer |
| lvr_evt | input | 1 | Low-voltage reset cause pulse |
| ila_evt | input | 1 | Illegal-address reset cause pulse |
| pll_locked | input | 1 | PLL lock status level |
| osc_up | input | 1 | Oscillator running status level |
| tick_ie | input | 1 | Timer interrupt enable |
| tick_irq | output | 1 | Timer interrupt request |

## Verification
The hardest situation to reach is a status level that changes while the system reset is held. It must set no change flag, either during the reset or in the first cycle after release, because the level watcher keeps following its input throughout the reset. The bench builds up timer and lock-change flags and then asserts the system reset. In the same cycle it issues a clearing write and an illegal-address event. While the reset is still held, it toggles the lock level and pulses the timer. After release it reads back the value that only correct domain handling can produce.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_TICK   = 7;
    localparam int BIT_POR    = 6;
    localparam int BIT_LVR    = 5;
    localparam int BIT_LOCKIF = 4;
    localparam int BIT_LOCK   = 3;
    localparam int BIT_ILA    = 2;
    localparam int BIT_OSCIF  = 1;
    localparam int BIT_OSCUP  = 0;

    localparam int N_EVT   = 3;   // tick, lock change, osc change
    localparam int N_CAUSE = 3;   // por, lvr, ila

    typedef enum logic [1:0] {
        ST_POWER_UP = 2'd0,
        ST_SYS_HOLD = 2'd1,
        ST_ACTIVE   = 2'd2
    } dom_state_t;
endpackage

// File: rtl/rsf_domain_fsm.sv
module rsf_domain_fsm
    import rsf_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    output logic accept
);
    dom_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_POWER_UP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER_UP: state_d = sys_rst ? ST_SYS_HOLD : ST_ACTIVE;
            ST_ACTIVE:   if (sys_rst) state_d = ST_SYS_HOLD;
            ST_SYS_HOLD: if (!sys_rst) state_d = ST_ACTIVE;
            default:     state_d = ST_POWER_UP;
        endcase
    end

    always_comb begin
        accept = (state_q == ST_ACTIVE) && !sys_rst;
    end
endmodule

// File: rtl/rsf_level_watch.sv
module rsf_level_watch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] prev_q;

    // The previous level is tracked in every state, also under system reset,
    // so that release never sees a stale level.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/rsf_event_flags.sv
module rsf_event_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         sys_rst,
    input  logic         accept,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                      flag_o[g] <= 1'b0;
            else if (sys_rst)                flag_o[g] <= 1'b0;
            else if (accept && set_i[g])     flag_o[g] <= 1'b1;
            else if (clr_i[g])               flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rsf_cause_flags.sv
module rsf_cause_flags #(
    parameter int                N       = 3,
    parameter logic [N-1:0]      PON_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    // Only power-on reset initialises these; system reset does not touch them.
    for (genvar g = 0; g < N; g++) begin : g_cause
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)         flag_o[g] <= PON_VAL[g];
            else if (set_i[g])  flag_o[g] <= 1'b1;
            else if (clr_i[g])  flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rsf_status_reg.sv
module rsf_status_reg
    import rsf_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(28)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tick_evt,
    input  logic              lvr_evt,
    input  logic              ila_evt,
    input  logic              pll_locked,
    input  logic              osc_up,
    input  logic              tick_ie,
    output logic              tick_irq
);
    logic               dom_accept;
    logic               addr_hit;
    logic               wr_hit;
    logic [REG_W-1:0]   clr_mask;
    logic [1:0]         lvl_chg;
    logic [N_EVT-1:0]   evt_set, evt_clr, evt_flag;
    logic [N_CAUSE-1:0] cause_set, cause_clr, cause_flag;
    logic               flag_tick, flag_lockif, flag_oscif;
    logic               flag_por, flag_lvr, flag_ila;
    logic [REG_W-1:0]   reg_val;

    rsf_domain_fsm u_dom (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .accept  (dom_accept)
    );

    rsf_level_watch #(.N(2)) u_watch (
        .clk   (clk),
        .por_n (por_n),
        .lvl_i ({pll_locked, osc_up}),
        .chg_o (lvl_chg)
    );

    assign addr_hit = (bus_addr == REG_ADDR);
    assign wr_hit   = bus_we && addr_hit && dom_accept;
    assign clr_mask = bus_wdata & {REG_W{wr_hit}};

    // Event flag order: [2] tick, [1] lock change, [0] osc change
    assign evt_set = {tick_evt, lvl_chg[1], lvl_chg[0]};
    assign evt_clr = {clr_mask[BIT_TICK], clr_mask[BIT_LOCKIF], clr_mask[BIT_OSCIF]};

    rsf_event_flags #(.N(N_EVT)) u_evt (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .accept  (dom_accept),
        .set_i   (evt_set),
        .clr_i   (evt_clr),
        .flag_o  (evt_flag)
    );

    // Cause flag order: [2] por, [1] lvr, [0] ila
    assign cause_set = {1'b0, lvr_evt, ila_evt};
    assign cause_clr = {clr_mask[BIT_POR], clr_mask[BIT_LVR], clr_mask[BIT_ILA]};

    rsf_cause_flags #(.N(N_CAUSE), .PON_VAL(3'b110)) u_cause (
        .clk    (clk),
        .por_n  (por_n),
        .set_i  (cause_set),
        .clr_i  (cause_clr),
        .flag_o (cause_flag)
    );

    assign flag_tick   = evt_flag[2];
    assign flag_lockif = evt_flag[1];
    assign flag_oscif  = evt_flag[0];
    assign flag_por    = cause_flag[2];
    assign flag_lvr    = cause_flag[1];
    assign flag_ila    = cause_flag[0];

    always_comb begin
        reg_val             = '0;
        reg_val[BIT_TICK]   = flag_tick;
        reg_val[BIT_POR]    = flag_por;
        reg_val[BIT_LVR]    = flag_lvr;
        reg_val[BIT_LOCKIF] = flag_lockif;
        reg_val[BIT_LOCK]   = pll_locked;
        reg_val[BIT_ILA]    = flag_ila;
        reg_val[BIT_OSCIF]  = flag_oscif;
        reg_val[BIT_OSCUP]  = osc_up;
    end

    assign bus_rdata = addr_hit ? reg_val : '0;
    assign tick_irq  = flag_tick && tick_ie;
endmodule

// File: rtl/rsf_status_chk.sv
module rsf_status_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(28)
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              tick_evt,
    input logic              lvr_evt,
    input logic              ila_evt,
    input logic              tick_ie,
    input logic              tick_irq,
    input logic              dom_accept,
    input logic              flag_tick,
    input logic              flag_lockif,
    input logic              flag_oscif,
    input logic              flag_por,
    input logic              flag_lvr,
    input logic              flag_ila
);
    a_r2_tick_sets: assert property (@(posedge clk) disable iff (!por_n)
        (tick_evt && dom_accept) |=> flag_tick);

    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
        $rose(tick_irq) |-> tick_ie);

    a_r4_sys_clears: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (!flag_tick && !flag_lockif && !flag_oscif));

    a_r4_sys_keeps_por: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> $stable(flag_por));

    a_r10_hold_keeps_ila: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && !ila_evt) |=> $stable(flag_ila));

    a_r8_lvr_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        lvr_evt |=> flag_lvr);

    a_r9_miss_keeps_por: assert property (@(posedge clk) disable iff (!por_n)
        (bus_we && bus_addr != REG_ADDR) |=> $stable(flag_por));
endmodule

bind rsf_status_reg rsf_status_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk_i (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst     (sys_rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .tick_evt    (tick_evt),
    .lvr_evt     (lvr_evt),
    .ila_evt     (ila_evt),
    .tick_ie     (tick_ie),
    .tick_irq    (tick_irq),
    .dom_accept  (dom_accept),
    .flag_tick   (flag_tick),
    .flag_lockif (flag_lockif),
    .flag_oscif  (flag_oscif),
    .flag_por    (flag_por),
    .flag_lvr    (flag_lvr),
    .flag_ila    (flag_ila)
);

// File: tb/rsf_status_reg_tb_top.sv
module rsf_status_reg_tb_top;
    localparam int         ADDR_W = 8;
    localparam logic [7:0] RADDR  = 8'd28;
    localparam logic [7:0] MISS   = 8'd29;

    logic       clk = 1'b0;
    logic       por_n, sys_rst, bus_we, tick_evt, lvr_evt, ila_evt;
    logic       pll_locked, osc_up, tick_ie, tick_irq;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    rsf_status_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR)) dut_i (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_evt(tick_evt), .lvr_evt(lvr_evt), .ila_evt(ila_evt),
        .pll_locked(pll_locked), .osc_up(osc_up), .tick_ie(tick_ie),
        .tick_irq(tick_irq)
    );

    // Vector: [22]tick [21]lock [20]osc [19]lvr [18]ila [17]we [16]addr_hit
    //         [15:8]wdata [7:0]expected read after the edge
    localparam int NV = 15;
    localparam logic [22:0] VEC [NV] = '{
        {7'b0000000, 8'h00, 8'h60},  // R1 idle after power-on
        {7'b1000000, 8'h00, 8'hE0},  // R2 tick sets bit 7
        {7'b0000011, 8'h00, 8'hE0},  // R2 write 0 no effect
        {7'b0000011, 8'h80, 8'h60},  // R2 write 1 clears
        {7'b0100000, 8'h00, 8'h78},  // R6 lock rises, R7 mirror
        {7'b0100011, 8'h10, 8'h68},  // R6 clear lock change
        {7'b0110000, 8'h00, 8'h6B},  // R6 osc rises
        {7'b0110011, 8'h0B, 8'h69},  // R7 status bits ignore writes
        {7'b1110011, 8'h80, 8'hE9},  // R8 tick set beats clear
        {7'b0110010, 8'hFF, 8'hE9},  // R9 write elsewhere
        {7'b0110011, 8'h60, 8'h89},  // R5 clear por and lvr causes
        {7'b0111100, 8'h00, 8'hAD},  // R5 lvr and ila events
        {7'b0010011, 8'h84, 8'h31},  // R6 lock falls, R5 clear ila
        {7'b0000011, 8'h30, 8'h02},  // R6 osc falls
        {7'b0001011, 8'h22, 8'h20}   // R8 lvr set beats clear
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_we = 1'b0; bus_addr = RADDR; bus_wdata = 8'h00;
        tick_evt = 1'b0; lvr_evt = 1'b0; ila_evt = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        bus_we = 1'b1; bus_addr = RADDR; bus_wdata = d;
        step(); idle_bus();
    endtask

    initial begin
        por_n = 1'b0; sys_rst = 1'b0; tick_ie = 1'b0;
        pll_locked = 1'b0; osc_up = 1'b0;
        idle_bus();
        repeat (3) step();
        por_n = 1'b1;
        repeat (2) step();
        #1;
        check("R1 power-on value", bus_rdata, 8'h60);
        check("R3 irq idle", {7'b0, tick_irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            tick_evt   = VEC[i][22];
            pll_locked = VEC[i][21];
            osc_up     = VEC[i][20];
            lvr_evt    = VEC[i][19];
            ila_evt    = VEC[i][18];
            bus_we     = VEC[i][17];
            bus_addr   = VEC[i][16] ? RADDR : MISS;
            bus_wdata  = VEC[i][15:8];
            step();
            idle_bus();
            #1;
            check($sformatf("vector %0d", i), bus_rdata, VEC[i][7:0]);
        end

        // R3: interrupt gating
        tick_evt = 1'b1; step(); idle_bus(); #1;
        check("R3 irq masked", {7'b0, tick_irq}, 8'h00);
        tick_ie = 1'b1; #1;
        check("R3 irq enabled", {7'b0, tick_irq}, 8'h01);
        wr(8'h80); #1;
        check("R3 irq after clear", {7'b0, tick_irq}, 8'h00);
        tick_ie = 1'b0;

        // R9: read at another address
        bus_addr = MISS; #1;
        check("R9 read miss", bus_rdata, 8'h00);
        bus_addr = RADDR;

        // R4 R5 R10 R6: system reset with events and writes
        tick_evt = 1'b1; pll_locked = 1'b1; step(); idle_bus(); #1;
        check("R6 pre-reset state", bus_rdata, 8'hB8);
        sys_rst = 1'b1; bus_we = 1'b1; bus_wdata = 8'h20; ila_evt = 1'b1;
        step(); idle_bus();
        pll_locked = 1'b0; tick_evt = 1'b1;
        step(); idle_bus();
        #1;
        check("R4 R5 R10 during hold", bus_rdata, 8'h24);
        sys_rst = 1'b0;
        repeat (2) step(); #1;
        check("R4 R6 after release", bus_rdata, 8'h24);

        // R7: mirrored status bits ignore writes
        pll_locked = 1'b1; osc_up = 1'b1; step(); #1;
        check("R7 levels up", bus_rdata, 8'h3F);
        wr(8'h09); #1;
        check("R7 write to status bits", bus_rdata, 8'h3F);
        wr(8'h3F); #1;
        check("R5 cause flags cleared", bus_rdata, 8'h09);

        // R1: second power-on reset restores cause flags and clears ila
        ila_evt = 1'b1; step(); idle_bus();
        tick_evt = 1'b1; step(); idle_bus(); #1;
        check("R1 before power-on", bus_rdata, 8'h8D);
        por_n = 1'b0; #1;
        check("R1 during power-on", bus_rdata, 8'h69);
        step(); por_n = 1'b1;
        repeat (2) step(); #1;
        check("R1 after power-on", bus_rdata, 8'h69);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule